// File: doc/BRIEF.md
# BCD Calendar Counter with Buffered Load

This block is the timekeeping core of a real-time clock. A one-cycle pulse that arrives once per second advances nine byte-wide registers: seconds, minutes, hours, date, month, weekday, year, a control byte and the century. All time and date fields use packed BCD. The hours byte holds either a 24-hour value or a 12-hour value with a PM flag. The date wraps at the true end of each month, and February gains a 29th day in leap years.

A serial front end, which is outside this block, supplies whole data bytes tagged with a register index. These bytes go into a shadow buffer and the counters keep running. When the frame ends and the front end marks it complete, every byte that was buffered is loaded into the counters in one cycle. An incomplete frame discards the buffer. To read, the front end pulses a snapshot request. All registers are then copied into a read image that does not change while the counters keep advancing. Two single-bit flags live inside the register bytes. One is an active-low enable for the 32 kHz output in the seconds byte. The other is an alarm-flag slot in the minutes byte, supplied from outside.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the read image holds seconds 00, minutes 00, hours 00, date 01, month 01, weekday 01, year 70, control 00 and century 19 (indices 0 to 8 in that order), and `clk32_en_o` is 1.
- R2: Each tick adds one to the BCD seconds. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours.
- R3: With hours bit 7 at 0 (24-hour mode), hours count 00 to 23 in bits 5:0. An hour carry from 23 gives 00 and advances the date.
- R4: With hours bit 7 at 1 (12-hour mode, bit 5 = PM, bits 4:0 = BCD 01 to 12), 11 goes to 12 and flips PM, and 12 goes to 01. Only the step from 11 PM to 12 AM advances the date.
- R5: The date wraps to 01 and advances the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02.
- R6: In month 02 the date wraps after 29 when the BCD year is divisible by 4 (00 included), and after 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the BCD century.
- R8: The weekday advances on every date advance and wraps from 7 to 1.
- R9: A byte written with `wr_en_i` changes no counter until `frame_end_i` arrives with `frame_done_i` high. Then every buffered byte loads at once and unwritten registers keep their value. A frame that ends with `frame_done_i` low discards the buffer.
- R10: `snap_i` copies all registers into the read image on the next edge. `rd_data_o` shows the image byte at `rd_idx_i` and stays fixed while ticks continue until the next `snap_i`.
- R11: A tick that arrives in the same cycle as a load is dropped, so the loaded seconds value is exact.
- R12: Seconds bit 7 is kept through counting, and `clk32_en_o` is its inverse. Written values of minutes bit 7 are ignored. In the read image, minutes bit 7 is `alm_flag_i` as sampled at the snapshot.
- R13: Control bit 7 is write-protect. While it is 1, a load changes only the control byte. Control bits 6:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse once per second |
| wr_en_i | input | 1 | Buffer one complete byte |
| wr_idx_i | input | 4 | Register index of the written byte |
| wr_data_i | input | 8 | Written byte |
| frame_end_i | input | 1 | Serial frame closes this cycle |
| frame_done_i | input | 1 | Qualifies frame_end_i: frame was complete |
| snap_i | input | 1 | Capture the read image |
| alm_flag_i | input | 1 | Alarm flag placed into minutes bit 7 of the image |
| rd_idx_i | input | 4 | Register index to read |
| rd_data_o | output | 8 | Read image byte at rd_idx_i |
| clk32_en_o | output | 1 | 32 kHz output enable (inverse of seconds bit 7) |

## Verification
A tick or a load changes the counters at the next clock edge. A snapshot request moves them into the read image one edge later, and `rd_data_o` follows `rd_idx_i` within the same cycle. The bench drives every pulse for exactly one cycle starting at a falling edge. It requests the snapshot only after the edge that took the tick or load, changes the read index one cycle after that, and samples shortly after the falling edge. This means each compared value is always one that has already been registered. `clk32_en_o` is sampled one full cycle after the load that sets it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NREG  = 9;
    localparam int IDX_W = $clog2(NREG);

    localparam int IX_SEC  = 0;
    localparam int IX_MIN  = 1;
    localparam int IX_HR   = 2;
    localparam int IX_DATE = 3;
    localparam int IX_MON  = 4;
    localparam int IX_WDAY = 5;
    localparam int IX_YEAR = 6;
    localparam int IX_CTRL = 7;
    localparam int IX_CENT = 8;

    typedef logic [NREG-1:0][7:0] regs_t;

    typedef struct packed {
        regs_t            data;
        logic [NREG-1:0]  vld;
    } shadow_t;

    typedef struct packed {
        regs_t cnt;
        regs_t snap;
    } core_t;

    // Two-digit BCD increment without range wrap; callers handle the limit.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by 4: tens*10 mod 4 equals 2 when the tens digit is odd.
    function automatic logic bcd_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {3'b000, yr[4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_cal_pkg::*;
(
    input  regs_t cur_i,
    output regs_t nxt_o
);
    logic       c_min, c_hr, c_day, c_mon, c_year;
    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;
    logic [7:0] last;

    always_comb begin
        nxt_o  = cur_i;
        c_min  = 1'b0;
        c_hr   = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        pm     = cur_i[IX_HR][5];
        h12    = cur_i[IX_HR][4:0];
        h24    = cur_i[IX_HR][5:0];
        last   = month_last(cur_i[IX_MON], cur_i[IX_YEAR]);

        // seconds, bit 7 (output enable) preserved
        if (cur_i[IX_SEC][6:0] == 7'h59) begin
            nxt_o[IX_SEC][6:0] = 7'h00;
            c_min = 1'b1;
        end else begin
            nxt_o[IX_SEC][6:0] = bcd_inc({1'b0, cur_i[IX_SEC][6:0]})[6:0];
        end

        // minutes
        if (c_min) begin
            if (cur_i[IX_MIN][6:0] == 7'h59) begin
                nxt_o[IX_MIN][6:0] = 7'h00;
                c_hr = 1'b1;
            end else begin
                nxt_o[IX_MIN][6:0] = bcd_inc({1'b0, cur_i[IX_MIN][6:0]})[6:0];
            end
        end

        // hours, 12 or 24 hour encoding
        if (c_hr) begin
            if (cur_i[IX_HR][7]) begin
                if (h12 == 5'h11) begin
                    h12   = 5'h12;
                    c_day = pm;
                    pm    = ~pm;
                end else if (h12 == 5'h12) begin
                    h12 = 5'h01;
                end else begin
                    h12 = bcd_inc({3'b000, h12})[4:0];
                end
                nxt_o[IX_HR] = {1'b1, cur_i[IX_HR][6], pm, h12};
            end else begin
                if (h24 == 6'h23) begin
                    h24   = 6'h00;
                    c_day = 1'b1;
                end else begin
                    h24 = bcd_inc({2'b00, h24})[5:0];
                end
                nxt_o[IX_HR] = {cur_i[IX_HR][7:6], h24};
            end
        end

        // date and weekday
        if (c_day) begin
            if (cur_i[IX_DATE] == last) begin
                nxt_o[IX_DATE] = 8'h01;
                c_mon = 1'b1;
            end else begin
                nxt_o[IX_DATE] = bcd_inc(cur_i[IX_DATE]);
            end
            if (cur_i[IX_WDAY] >= 8'h07) nxt_o[IX_WDAY] = 8'h01;
            else                         nxt_o[IX_WDAY] = cur_i[IX_WDAY] + 8'h01;
        end

        // month
        if (c_mon) begin
            if (cur_i[IX_MON] == 8'h12) begin
                nxt_o[IX_MON] = 8'h01;
                c_year = 1'b1;
            end else begin
                nxt_o[IX_MON] = bcd_inc(cur_i[IX_MON]);
            end
        end

        // year and century
        if (c_year) begin
            if (cur_i[IX_YEAR] == 8'h99) begin
                nxt_o[IX_YEAR] = 8'h00;
                nxt_o[IX_CENT] = (cur_i[IX_CENT] == 8'h99) ? 8'h00 : bcd_inc(cur_i[IX_CENT]);
            end else begin
                nxt_o[IX_YEAR] = bcd_inc(cur_i[IX_YEAR]);
            end
        end
    end
endmodule

// File: rtl/rtc_shadow_buf.sv
module rtc_shadow_buf
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic             frame_end_i,
    output regs_t            data_o,
    output logic [NREG-1:0]  vld_o
);
    shadow_t shd_d, shd_q;

    always_comb begin
        shd_d = shd_q;
        if (frame_end_i) begin
            shd_d.vld = '0;
        end else if (wr_en_i && (int'(wr_idx_i) < NREG)) begin
            for (int i = 0; i < NREG; i++) begin
                if (int'(wr_idx_i) == i) begin
                    shd_d.data[i] = wr_data_i;
                    shd_d.vld[i]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shd_q <= '0;
        else        shd_q <= shd_d;
    end

    assign data_o = shd_q.data;
    assign vld_o  = shd_q.vld;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter logic [7:0] POR_YEAR    = 8'h70,
    parameter logic [7:0] POR_CENTURY = 8'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_data_i,
    input  logic             frame_end_i,
    input  logic             frame_done_i,
    input  logic             snap_i,
    input  logic             alm_flag_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [7:0]       rd_data_o,
    output logic             clk32_en_o
);
    localparam regs_t POR_REGS = {POR_CENTURY, 8'h00, POR_YEAR, 8'h01, 8'h01,
                                  8'h01, 8'h00, 8'h00, 8'h00};

    core_t           st_d, st_q;
    regs_t           step_nxt;
    regs_t           shd_data;
    logic [NREG-1:0] shd_vld;
    logic            load_now;
    logic            wp_on;
    regs_t           cnt_q;
    regs_t           snap_q;

    rtc_shadow_buf u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_idx_i    (wr_idx_i),
        .wr_data_i   (wr_data_i),
        .frame_end_i (frame_end_i),
        .data_o      (shd_data),
        .vld_o       (shd_vld)
    );

    rtc_bcd_step u_step (
        .cur_i (st_q.cnt),
        .nxt_o (step_nxt)
    );

    always_comb begin
        st_d     = st_q;
        load_now = frame_end_i && frame_done_i && (|shd_vld);
        wp_on    = st_q.cnt[IX_CTRL][7];

        if (load_now) begin
            for (int i = 0; i < NREG; i++) begin
                if (shd_vld[i] && (!wp_on || i == IX_CTRL)) st_d.cnt[i] = shd_data[i];
            end
            st_d.cnt[IX_MIN][7]    = 1'b0;
            st_d.cnt[IX_CTRL][6:0] = 7'h00;
        end else if (tick_i) begin
            st_d.cnt = step_nxt;
        end

        if (snap_i) begin
            st_d.snap             = st_q.cnt;
            st_d.snap[IX_MIN][7]  = alm_flag_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= POR_REGS;
            st_q.snap <= POR_REGS;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q      = st_q.cnt;
    assign snap_q     = st_q.snap;
    assign rd_data_o  = (int'(rd_idx_i) < NREG) ? st_q.snap[rd_idx_i] : 8'h00;
    assign clk32_en_o = ~st_q.cnt[IX_SEC][7];
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk
    import rtc_cal_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            tick_i,
    input logic            frame_end_i,
    input logic            frame_done_i,
    input logic            snap_i,
    input logic            clk32_en_o,
    input regs_t           cnt_q,
    input regs_t           snap_q,
    input logic [NREG-1:0] shd_vld
);
    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(frame_end_i && frame_done_i)) |=> $stable(cnt_q)); // R9

    AST_BUFFER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_i |=> (shd_vld == '0)); // R9

    AST_IMAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_i |=> $stable(snap_q)); // R10

    AST_TICK_KEEPS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !frame_end_i) |=> $stable(clk32_en_o)); // R12

    AST_MIN_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[IX_MIN][7] == 1'b0); // R12

    AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[IX_CTRL][6:0] == 7'h00); // R13

    AST_PROTECT_HOLDS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && frame_done_i && cnt_q[IX_CTRL][7] && !tick_i)
        |=> $stable(cnt_q[IX_SEC])); // R13
endmodule

bind rtc_calendar_core rtc_calendar_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .frame_end_i  (frame_end_i),
    .frame_done_i (frame_done_i),
    .snap_i       (snap_i),
    .clk32_en_o   (clk32_en_o),
    .cnt_q        (cnt_q),
    .snap_q       (snap_q),
    .shd_vld      (shd_vld)
);

// File: tb/rtc_calendar_core_test.sv
module rtc_calendar_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [3:0] wr_idx_i = 4'd0;
    logic [7:0] wr_data_i = 8'h00;
    logic       frame_end_i = 1'b0;
    logic       frame_done_i = 1'b0;
    logic       snap_i = 1'b0;
    logic       alm_flag_i = 1'b0;
    logic [3:0] rd_idx_i = 4'd0;
    logic [7:0] rd_data_o;
    logic       clk32_en_o;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rtc_calendar_core uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
        .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .frame_end_i(frame_end_i),
        .frame_done_i(frame_done_i), .snap_i(snap_i), .alm_flag_i(alm_flag_i),
        .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .clk32_en_o(clk32_en_o)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_byte(input int idx, input logic [7:0] v);
        @(negedge clk);
        wr_en_i = 1'b1; wr_idx_i = 4'(idx); wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic end_frame(input bit done, input bit with_tick);
        @(negedge clk);
        frame_end_i = 1'b1; frame_done_i = done; tick_i = with_tick;
        @(negedge clk);
        frame_end_i = 1'b0; frame_done_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic load(input logic [7:0] s, m, h, dt, mo, wd, yr, ct, ce);
        wr_byte(0, s); wr_byte(1, m); wr_byte(2, h); wr_byte(3, dt);
        wr_byte(4, mo); wr_byte(5, wd); wr_byte(6, yr); wr_byte(7, ct);
        wr_byte(8, ce);
        end_frame(1'b1, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_i = 1'b1;
            @(negedge clk); tick_i = 1'b0;
        end
    endtask

    task automatic snap();
        @(negedge clk); snap_i = 1'b1;
        @(negedge clk); snap_i = 1'b0;
    endtask

    task automatic peek(input int idx, output logic [7:0] v);
        @(negedge clk); rd_idx_i = 4'(idx);
        #1 v = rd_data_o;
    endtask

    task automatic expect_reg(input string req, input int idx, input logic [7:0] exp);
        logic [7:0] v;
        peek(idx, v);
        chk(req, $sformatf("reg%0d", idx), v, exp);
    endtask

    task automatic t_reset();
        logic [7:0] por [9] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h70, 8'h00, 8'h19};
        snap();
        for (int i = 0; i < 9; i++) expect_reg("R1", i, por[i]);
        chk("R1", "clk32_en", {7'd0, clk32_en_o}, 8'h01);
    endtask

    task automatic t_sec_min();
        load(8'h58, 8'h59, 8'h05, 8'h10, 8'h05, 8'h02, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R2", 0, 8'h59);
        ticks(1); snap();
        expect_reg("R2", 0, 8'h00);
        expect_reg("R2", 1, 8'h00);
        expect_reg("R2", 2, 8'h06);
    endtask

    task automatic t_hour24();
        load(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h03, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R3", 2, 8'h00);
        expect_reg("R3", 3, 8'h16);
        expect_reg("R8", 5, 8'h04);
    endtask

    task automatic t_hour12();
        load(8'h59, 8'h59, 8'h91, 8'h10, 8'h05, 8'h02, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R4", 2, 8'hB2);
        expect_reg("R4", 3, 8'h10);
        load(8'h59, 8'h59, 8'hB2, 8'h10, 8'h05, 8'h02, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R4", 2, 8'hA1);
        load(8'h59, 8'h59, 8'hB1, 8'h10, 8'h05, 8'h02, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R4", 2, 8'h92);
        expect_reg("R4", 3, 8'h11);
    endtask

    task automatic day_roll(input logic [7:0] dt, mo, yr, input logic [7:0] exp_dt, exp_mo, input string req);
        load(8'h59, 8'h59, 8'h23, dt, mo, 8'h01, yr, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg(req, 3, exp_dt);
        expect_reg(req, 4, exp_mo);
    endtask

    task automatic t_month_len();
        day_roll(8'h30, 8'h04, 8'h21, 8'h01, 8'h05, "R5");
        day_roll(8'h31, 8'h01, 8'h21, 8'h01, 8'h02, "R5");
        day_roll(8'h30, 8'h03, 8'h21, 8'h31, 8'h03, "R5");
        day_roll(8'h30, 8'h11, 8'h21, 8'h01, 8'h12, "R5");
    endtask

    task automatic t_leap();
        day_roll(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, "R6");
        day_roll(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, "R6");
        day_roll(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, "R6");
        day_roll(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, "R6");
        day_roll(8'h28, 8'h02, 8'h10, 8'h01, 8'h03, "R6");
    endtask

    task automatic t_year();
        load(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h05, 8'h99, 8'h00, 8'h19);
        ticks(1); snap();
        expect_reg("R7", 3, 8'h01);
        expect_reg("R7", 4, 8'h01);
        expect_reg("R7", 6, 8'h00);
        expect_reg("R7", 8, 8'h20);
    endtask

    task automatic t_wday();
        load(8'h59, 8'h59, 8'h23, 8'h12, 8'h06, 8'h07, 8'h21, 8'h00, 8'h20);
        ticks(1); snap();
        expect_reg("R8", 5, 8'h01);
    endtask

    task automatic t_buffer();
        load(8'h10, 8'h20, 8'h08, 8'h12, 8'h06, 8'h02, 8'h21, 8'h00, 8'h20);
        wr_byte(0, 8'h45);
        ticks(2); snap();
        expect_reg("R9", 0, 8'h12);
        end_frame(1'b1, 1'b0);
        snap();
        expect_reg("R9", 0, 8'h45);
        expect_reg("R9", 1, 8'h20);
        wr_byte(1, 8'h33);
        end_frame(1'b0, 1'b0);
        end_frame(1'b1, 1'b0);
        snap();
        expect_reg("R9", 1, 8'h20);
    endtask

    task automatic t_snapshot();
        load(8'h05, 8'h00, 8'h08, 8'h12, 8'h06, 8'h02, 8'h21, 8'h00, 8'h20);
        snap();
        ticks(3);
        expect_reg("R10", 0, 8'h05);
        snap();
        expect_reg("R10", 0, 8'h08);
    endtask

    task automatic t_collision();
        load(8'h05, 8'h00, 8'h08, 8'h12, 8'h06, 8'h02, 8'h21, 8'h00, 8'h20);
        wr_byte(0, 8'h30);
        end_frame(1'b1, 1'b1);
        snap();
        expect_reg("R11", 0, 8'h30);
        ticks(1); snap();
        expect_reg("R11", 0, 8'h31);
    endtask

    task automatic t_flags();
        load(8'hD9, 8'h85, 8'h08, 8'h12, 8'h06, 8'h02, 8'h21, 8'h00, 8'h20);
        @(negedge clk);
        chk("R12", "clk32_en off", {7'd0, clk32_en_o}, 8'h00);
        ticks(1); snap();
        expect_reg("R12", 0, 8'h80);
        expect_reg("R12", 1, 8'h06);
        chk("R12", "clk32_en kept", {7'd0, clk32_en_o}, 8'h00);
        alm_flag_i = 1'b1;
        snap();
        expect_reg("R12", 1, 8'h86);
        alm_flag_i = 1'b0;
        wr_byte(0, 8'h10);
        end_frame(1'b1, 1'b0);
        @(negedge clk);
        chk("R12", "clk32_en on", {7'd0, clk32_en_o}, 8'h01);
    endtask

    task automatic t_protect();
        load(8'h05, 8'h00, 8'h08, 8'h12, 8'h06, 8'h02, 8'h21, 8'h00, 8'h20);
        wr_byte(7, 8'hFF);
        end_frame(1'b1, 1'b0);
        snap();
        expect_reg("R13", 7, 8'h80);
        wr_byte(0, 8'h44);
        wr_byte(6, 8'h55);
        end_frame(1'b1, 1'b0);
        snap();
        expect_reg("R13", 0, 8'h05);
        expect_reg("R13", 6, 8'h21);
        wr_byte(7, 8'h00);
        end_frame(1'b1, 1'b0);
        wr_byte(0, 8'h44);
        end_frame(1'b1, 1'b0);
        snap();
        expect_reg("R13", 7, 8'h00);
        expect_reg("R13", 0, 8'h44);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sec_min();
        t_hour24();
        t_hour12();
        t_month_len();
        t_leap();
        t_year();
        t_wday();
        t_buffer();
        t_snapshot();
        t_collision();
        t_flags();
        t_protect();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule